// File: doc/BRIEF.md
# AES Decryption Round-Key Converter

This block turns a forward (encryption) AES key schedule into the schedule that the equivalent inverse cipher uses. A start pulse with a round count launches one pass. The block reads the forward round keys from a source key memory and writes the converted keys to a destination key memory, one key per clock. In that inverse-cipher form the decryption round can apply the inverse column mix before the key XOR. This is valid because the column mix is linear over GF(2^8) and the key addition is a plain XOR, so the inner round keys must carry the inverse column mix themselves.

Both memory ports have a fixed timing and no back-pressure. The source memory returns the 128-bit word for an address one cycle after the read strobe. The destination memory accepts a write in every cycle that the write strobe is high. A single-cycle done pulse marks the end of a pass. A single-cycle error pulse reports a round count that cannot be used.

Top module: `aes_rk_inverter`

## Requirements
- R1: Only a round count of 10, 12 or 14 starts a pass. For any other value, a start pulse on an idle block raises `err_o` for exactly one cycle, in the cycle after the start edge. It issues no read and no write and gives no done pulse.
- R2: The key written at index 0 equals the forward key at index Nr, bit for bit unchanged.
- R3: For 1 <= i <= Nr-1, the key written at index i equals InvMixColumns of the forward key at index Nr-i. Byte b of a key occupies bits [8b+7:8b]. Column c is formed by bytes 4c..4c+3, with byte 4c+r in row r. Output row r of a column is 0e*a[r] ^ 0b*a[r+1] ^ 0d*a[r+2] ^ 09*a[r+3], with row indices taken mod 4. The products are in GF(2^8) with reduction polynomial 0x11b.
- R4: The key written at index Nr equals the forward key at index 0, bit for bit unchanged.
- R5: Key i sits at byte address 16*i in both memories. A pass reads each of the Nr+1 forward keys exactly once, in descending index order. It writes each of the Nr+1 output keys exactly once, in ascending index order.
- R6: Let the clock edge that samples the start pulse be edge E. Read k (of forward key Nr-k) is presented in the cycle after edge E+k. Write k is presented in the cycle after edge E+2+k, so the writes occupy consecutive cycles. `done_o` is high for exactly one cycle, the cycle after the write of key Nr.
- R7: A start pulse that arrives while a pass is in progress is ignored, whatever its round count. The running pass finishes with its original count, and no error is raised.
- R8: While reset is held, all strobes (`rd_en_o`, `wr_en_o`, `done_o`, `err_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to convert a schedule |
| nr_i | input | 4 | Round count, sampled with the start pulse |
| rd_en_o | output | 1 | Read strobe to the source key memory |
| rd_addr_o | output | 8 | Byte address of the forward key being read |
| rd_data_i | input | 128 | Source memory data, valid one cycle after the read strobe |
| wr_en_o | output | 1 | Write strobe to the destination key memory |
| wr_addr_o | output | 8 | Byte address of the output key being written |
| wr_data_o | output | 128 | Output key data |
| done_o | output | 1 | One-cycle pulse after the last key is written |
| err_o | output | 1 | One-cycle pulse for an unusable round count |

## Verification
The bench goes after the two edge keys. A design that mixed every key, or mixed none, would corrupt index 0 and Nr, or leave the inner keys wrong. A constant column whose inverse mix is known in closed form catches a swapped matrix coefficient or a rotation in the wrong direction. The bench checks the exact read and write cycle of every key. An off-by-one in the reverse order or in the read-latency alignment would show up as a key shifted by one slot, or as a gap in the write burst. The bench also sweeps every illegal round count and sends stray start pulses into a running pass. A design that restarted or re-latched the count would produce an extra write, a second done or a wrong key count.

// File: rtl/aes_rk_pkg.sv
package aes_rk_pkg;

  // multiply by x in GF(2^8), modulus 0x11b
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // multiply by a 4-bit constant via doubling chain
  function automatic logic [7:0] gf_mul_k(input logic [7:0] a, input logic [3:0] k);
    logic [7:0] x2, x4, x8;
    x2 = gf_dbl(a);
    x4 = gf_dbl(x2);
    x8 = gf_dbl(x4);
    return (k[0] ? a : 8'h00) ^ (k[1] ? x2 : 8'h00) ^
           (k[2] ? x4 : 8'h00) ^ (k[3] ? x8 : 8'h00);
  endfunction

  typedef enum logic { ST_IDLE, ST_RUN } conv_state_t;

endpackage

// File: rtl/rk_col_unmix.sv
module rk_col_unmix
  import aes_rk_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  localparam int ROWS = 4;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int R1I = (r + 1) % ROWS;
    localparam int R2I = (r + 2) % ROWS;
    localparam int R3I = (r + 3) % ROWS;
    assign col_o[8*r +: 8] = gf_mul_k(col_i[8*r   +: 8], 4'he) ^
                             gf_mul_k(col_i[8*R1I +: 8], 4'hb) ^
                             gf_mul_k(col_i[8*R2I +: 8], 4'hd) ^
                             gf_mul_k(col_i[8*R3I +: 8], 4'h9);
  end

endmodule

// File: rtl/rk_key_unmix.sv
module rk_key_unmix #(
  parameter int KEY_W = 128,
  localparam int COLS = KEY_W / 32
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [KEY_W-1:0] key_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    rk_col_unmix u_col (
      .col_i (key_i[32*c +: 32]),
      .col_o (key_o[32*c +: 32])
    );
  end

endmodule

// File: rtl/rk_ctrl.sv
module rk_ctrl
  import aes_rk_pkg::*;
#(
  parameter int NR_MAX = 14,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(NR_MAX + 1),
  localparam int OFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  nr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              cap_o,
  output logic              cap_inner_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o,
  output logic              err_o
);

  conv_state_t      state_q;
  logic [IDX_W-1:0] nr_q;
  logic             rd_en_q;
  logic [IDX_W-1:0] rd_idx_q;   // forward index being read
  logic [IDX_W-1:0] tag_q;      // output index of that read
  logic             cap_q, cap_inner_q, cap_last_q;
  logic [IDX_W-1:0] cap_idx_q;
  logic             wr_en_q, wr_last_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic             done_q, err_q;
  logic             nr_ok;

  assign nr_ok = ((nr_i == IDX_W'(10)) || (nr_i == IDX_W'(12)) ||
                  (nr_i == IDX_W'(14))) && (int'(nr_i) <= NR_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      nr_q        <= '0;
      rd_en_q     <= 1'b0;
      rd_idx_q    <= '0;
      tag_q       <= '0;
      cap_q       <= 1'b0;
      cap_inner_q <= 1'b0;
      cap_last_q  <= 1'b0;
      cap_idx_q   <= '0;
      wr_en_q     <= 1'b0;
      wr_last_q   <= 1'b0;
      wr_idx_q    <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (nr_ok) begin
              state_q  <= ST_RUN;
              nr_q     <= nr_i;
              rd_en_q  <= 1'b1;
              rd_idx_q <= nr_i;
              tag_q    <= '0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (rd_en_q && (tag_q != nr_q)) begin
            rd_en_q  <= 1'b1;
            rd_idx_q <= rd_idx_q - 1'b1;
            tag_q    <= tag_q + 1'b1;
          end
          if (wr_en_q && wr_last_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // data returns from memory one cycle after the read strobe
      cap_q       <= rd_en_q;
      cap_idx_q   <= tag_q;
      cap_inner_q <= rd_en_q && (tag_q != '0) && (tag_q != nr_q);
      cap_last_q  <= rd_en_q && (tag_q == nr_q);
      // output register stage
      wr_en_q   <= cap_q;
      wr_idx_q  <= cap_idx_q;
      wr_last_q <= cap_q && cap_last_q;
    end
  end

  assign rd_en_o     = rd_en_q;
  assign rd_addr_o   = ADDR_W'({rd_idx_q, {OFS_W{1'b0}}});
  assign cap_o       = cap_q;
  assign cap_inner_o = cap_inner_q;
  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = ADDR_W'({wr_idx_q, {OFS_W{1'b0}}});
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R1: an error pulse never overlaps any memory traffic
  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!rd_en_q && !cap_q && !wr_en_q && !done_q));

  // R5: consecutive reads walk the forward schedule downwards
  p_rd_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_q && $past(rd_en_q)) |-> (rd_idx_q == $past(rd_idx_q) - 1'b1));

  // R6: writes form an unbroken ascending burst
  p_wr_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_q && !wr_last_q) |=> (wr_en_q && (wr_idx_q == $past(wr_idx_q) + 1'b1)));

  // R6: done follows the last write and lasts one cycle
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_q && wr_last_q) |=> (done_q && !wr_en_q));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a start during a pass leaves the latched count alone
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && start_i) |=> $stable(nr_q));

endmodule

// File: rtl/aes_rk_inverter.sv
module aes_rk_inverter #(
  parameter int NR_MAX = 14,
  parameter int ADDR_W = 8,
  parameter int KEY_W  = 128,
  localparam int IDX_W = $clog2(NR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  nr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [KEY_W-1:0]  rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [KEY_W-1:0]  wr_data_o,
  output logic              done_o,
  output logic              err_o
);

  logic             cap, cap_inner;
  logic [KEY_W-1:0] unmixed;
  logic [KEY_W-1:0] wr_data_q;

  rk_ctrl #(
    .NR_MAX (NR_MAX),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .nr_i        (nr_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .cap_o       (cap),
    .cap_inner_o (cap_inner),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  rk_key_unmix #(
    .KEY_W (KEY_W)
  ) u_unmix (
    .key_i (rd_data_i),
    .key_o (unmixed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_data_q <= '0;
    end else if (cap) begin
      wr_data_q <= cap_inner ? unmixed : rd_data_i;
    end
  end

  assign wr_data_o = wr_data_q;

  // R2, R4: the first and last keys pass through untouched
  p_edge_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !cap_inner) |=> (wr_en_o && (wr_data_o == $past(rd_data_i))));

  // R3: inner keys are the column-unmixed source word
  p_inner_mix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cap_inner) |=> (wr_en_o && (wr_data_o == $past(unmixed))));

endmodule

// File: tb/aes_rk_inverter_tb.sv
module aes_rk_inverter_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [3:0]   nr_i = '0;
  logic         rd_en_o, wr_en_o, done_o, err_o;
  logic [7:0]   rd_addr_o, wr_addr_o;
  logic [127:0] rd_data_i = '0;
  logic [127:0] wr_data_o;

  aes_rk_inverter u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nr_i(nr_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [127:0] src [16];
  logic [127:0] dst [16];
  int wr_cyc [16];
  int rd_cyc [16];
  int cyc = 0;
  int wr_cnt, rd_cnt, done_cnt, err_cnt, done_cyc, err_cyc, bad_addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rd_en_o) rd_data_i <= src[rd_addr_o[7:4]];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en_o) begin
        rd_cnt++;
        rd_cyc[rd_addr_o[7:4]] = cyc;
        if (rd_addr_o[3:0] != 0) bad_addr++;
      end
      if (wr_en_o) begin
        wr_cnt++;
        wr_cyc[wr_addr_o[7:4]] = cyc;
        dst[wr_addr_o[7:4]] = wr_data_o;
        if (wr_addr_o[3:0] != 0) bad_addr++;
      end
      if (done_o) begin done_cnt++; done_cyc = cyc; end
      if (err_o)  begin err_cnt++;  err_cyc = cyc;  end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_imc(input logic [127:0] k);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[8*(4*c+r) +: 8] = ref_mul(k[8*(4*c+r) +: 8], 8'h0e) ^
                            ref_mul(k[8*(4*c+(r+1)%4) +: 8], 8'h0b) ^
                            ref_mul(k[8*(4*c+(r+2)%4) +: 8], 8'h0d) ^
                            ref_mul(k[8*(4*c+(r+3)%4) +: 8], 8'h09);
    return o;
  endfunction

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  task automatic clear_log();
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0; err_cnt = 0;
    done_cyc = -1; err_cyc = -1; bad_addr = 0;
    for (int i = 0; i < 16; i++) begin
      dst[i] = {4{32'hdead_beef}};
      wr_cyc[i] = -1;
      rd_cyc[i] = -1;
    end
  endtask

  // mode 0: pseudo-random, 1: known column, 2: indexed bytes
  task automatic fill_src(input int mode);
    for (int f = 0; f < 16; f++) begin
      if (mode == 0) src[f] = {next_rand(), next_rand(), next_rand(), next_rand()};
      else if (mode == 1) src[f] = {4{32'hbca1_4d8e}};
      else for (int b = 0; b < 16; b++) src[f][8*b +: 8] = 8'(f * 17 + b * 5);
    end
  endtask

  task automatic run_pass(input int nr, input int mode, input bit stray);
    int t0;
    logic [127:0] exp;
    fill_src(mode);
    clear_log();
    @(negedge clk);
    t0 = cyc;
    start_i = 1'b1; nr_i = 4'(nr);
    @(negedge clk);
    start_i = 1'b0;
    if (stray) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; nr_i = 4'd12;   // R7 stray legal start
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1; nr_i = 4'd3;    // R7 stray illegal start
      @(negedge clk);
      start_i = 1'b0;
    end
    while (cyc < t0 + nr + 8) @(negedge clk);
    #1;
    for (int k = 0; k <= nr; k++) begin
      if (k == 0) begin
        exp = src[nr];
        chk(dst[k] == exp, "R2 first key copy", dst[k], exp);
      end else if (k == nr) begin
        exp = src[0];
        chk(dst[k] == exp, "R4 last key copy", dst[k], exp);
      end else begin
        exp = (mode == 1) ? {4{32'h4553_13db}} : ref_imc(src[nr-k]);
        chk(dst[k] == exp, "R3 inner key unmix", dst[k], exp);
      end
      chk(wr_cyc[k] == t0 + 3 + k, "R6 write cycle", 128'(wr_cyc[k]), 128'(t0 + 3 + k));
      chk(rd_cyc[nr-k] == t0 + 1 + k, "R6 read cycle", 128'(rd_cyc[nr-k]), 128'(t0 + 1 + k));
    end
    chk(wr_cnt == nr + 1, "R5 write count", 128'(wr_cnt), 128'(nr + 1));
    chk(rd_cnt == nr + 1, "R5 read count", 128'(rd_cnt), 128'(nr + 1));
    chk(bad_addr == 0, "R5 byte offset", 128'(bad_addr), 128'(0));
    chk(done_cnt == 1, "R6 done count", 128'(done_cnt), 128'(1));
    chk(done_cyc == t0 + 4 + nr, "R6 done cycle", 128'(done_cyc), 128'(t0 + 4 + nr));
    chk(err_cnt == 0, stray ? "R7 no error on busy start" : "R1 no error", 128'(err_cnt), 128'(0));
  endtask

  task automatic run_bad(input int nr);
    int t0;
    clear_log();
    @(negedge clk);
    t0 = cyc;
    start_i = 1'b1; nr_i = 4'(nr);
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    #1;
    chk(err_cnt == 1, "R1 error pulse", 128'(err_cnt), 128'(1));
    chk(err_cyc == t0 + 1, "R1 error cycle", 128'(err_cyc), 128'(t0 + 1));
    chk(wr_cnt + rd_cnt + done_cnt == 0, "R1 no traffic", 128'(wr_cnt + rd_cnt + done_cnt), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_log();
    repeat (4) @(negedge clk);
    chk({rd_en_o, wr_en_o, done_o, err_o} == 4'b0, "R8 reset strobes",
        128'({rd_en_o, wr_en_o, done_o, err_o}), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_pass(10, 0, 0);
    run_pass(12, 0, 0);
    run_pass(14, 0, 0);
    run_pass(10, 1, 0);
    run_pass(14, 1, 0);
    run_pass(12, 2, 0);
    run_pass(14, 2, 0);
    run_pass(10, 0, 1);
    for (int n = 0; n < 16; n++)
      if (n != 10 && n != 12 && n != 14) run_bad(n);
    run_pass(12, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule